// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block arbitrates interrupt requests for an 8051-style processor core. There are eight sources: four active-low external pins, three timer overflow lines and one serial-port line. The external pins pass through a two-flop synchroniser. Each one can be set to latch a pending flag on a falling edge, or to present its flag as a copy of the pin level. Timer and serial requests are level inputs that the peripheral holds until its own flag is cleared.

Every source has an enable bit and a priority bit. A global enable gates all of them. When a request is accepted, the controller raises a one-cycle valid strobe together with an 8-bit vector and a 3-bit source index. It also records the accepted level in a two-entry in-service stack, and the return-from-interrupt input pops that stack. Software reaches the control state through a simple special-function-register port: a write strobe, an address, write data and combinational read data.

The extra external sources 2 and 3 share one control byte. That byte packs type, flag, enable and priority for both sources. These two sources rank at the bottom of the fixed resolution order.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the registers at A8H, B8H, 88H and C0H all read 00H and `vec_valid` is low.
- R2: An accepted request gives one `vec_valid` pulse. `idx` carries the source number and `vec` equals idx*8+3. The source numbers are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 6 external 2, 7 external 3.
- R3: When several requests of the same level are eligible, the lowest source number is accepted first.
- R4: Register A8H holds the global enable in bit 7 and the enables for sources 0 to 5 in bits 5:0. While the global enable is 0, no request is accepted.
- R5: Register B8H holds the priorities for sources 0 to 5 in bits 5:0, where 1 means high. A high request preempts a running low handler. Nothing preempts a high handler, and a low request waits while a low handler runs. A `reti` pulse releases the most recent in-service level.
- R6: Register C0H holds, from bit 7 down to bit 0: priority 3, enable 3, flag 3, type 3, priority 2, enable 2, flag 2, type 2. Writes to it read back unchanged when no pin activity occurs.
- R7: With a type bit at 1, a falling edge on the synchronised pin (high on one sample, low on the next) sets the flag. Servicing that source clears the flag.
- R8: With a type bit at 0, the flag follows the inverted synchronised pin and is left set when the source is serviced.
- R9: Software can set or clear an edge-mode flag by writing its register. A hardware edge set in the same cycle as a software clear leaves the flag set.
- R10: Register 88H holds type 0 in bit 0, flag 0 in bit 1, type 1 in bit 2 and flag 1 in bit 3, and these bits behave as in R7 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 4 | External interrupt pins 0..3, active low, asynchronous |
| tmr_req | input | 3 | Timer 0, 1, 2 overflow requests, level |
| ser_req | input | 1 | Serial port request, level |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data, combinational on `sfr_addr` |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_valid | output | 1 | One-cycle strobe for an accepted request |
| vec | output | 8 | Vector address of the accepted source |
| idx | output | 3 | Number of the accepted source |

## Verification
The hardest case to reach is a software clear of an edge flag that lands in exactly the cycle in which the synchronised falling edge is recognised. The stimulus drops the pin just after a falling clock edge and lets two rising edges pass through the synchroniser. It then drives the clearing write so that it is captured on the third rising edge, which is when the flag gets set. Nested servicing is reached by holding a low-priority timer line, then raising a high-priority line. A further low request is added while both handlers are open, and the stack is then released one level at a time.

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
  parameter logic [7:0] A_EN  = 8'hA8,
  parameter logic [7:0] A_PRI = 8'hB8,
  parameter logic [7:0] A_EXL = 8'h88,
  parameter logic [7:0] A_EXH = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ext_n,
  input  logic [2:0] tmr_req,
  input  logic       ser_req,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       reti,
  output logic       vec_valid,
  output logic [7:0] vec,
  output logic [2:0] idx
);

  logic       ea;
  logic [7:0] en, pri;
  logic [3:0] typ, flg, s1, s2, s3;
  logic       ins_hi, ins_lo;

  wire wr_en  = sfr_we && sfr_addr == A_EN;
  wire wr_pri = sfr_we && sfr_addr == A_PRI;
  wire wr_exl = sfr_we && sfr_addr == A_EXL;
  wire wr_exh = sfr_we && sfr_addr == A_EXH;

  wire [3:0] sw_we  = {wr_exh, wr_exh, wr_exl, wr_exl};
  wire [3:0] sw_val = {sfr_wdata[5], sfr_wdata[1], sfr_wdata[3], sfr_wdata[1]};
  wire [3:0] fall   = s3 & ~s2;

  wire [7:0] req  = {flg[3], flg[2], tmr_req[2], ser_req, tmr_req[1], flg[1], tmr_req[0], flg[0]};
  wire [7:0] cand = ea ? (req & en) : 8'h00;
  wire [7:0] hi   = cand & pri;
  wire [7:0] lo   = cand & ~pri;

  wire       take_hi = (|hi) && !ins_hi;
  wire       take_lo = (|lo) && !ins_hi && !ins_lo;
  wire [7:0] pick    = take_hi ? hi : (take_lo ? lo : 8'h00);
  wire       fire    = |pick;

  logic [2:0] gidx;
  always_comb begin
    gidx = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (pick[i]) gidx = 3'(i);
  end

  wire [3:0] svc = {fire && gidx == 3'd7, fire && gidx == 3'd6,
                    fire && gidx == 3'd2, fire && gidx == 3'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea  <= 1'b0;
      en  <= '0;
      pri <= '0;
      typ <= '0;
    end else begin
      if (wr_en) begin
        ea      <= sfr_wdata[7];
        en[5:0] <= sfr_wdata[5:0];
      end
      if (wr_pri) pri[5:0] <= sfr_wdata[5:0];
      if (wr_exl) begin
        typ[0] <= sfr_wdata[0];
        typ[1] <= sfr_wdata[2];
      end
      if (wr_exh) begin
        pri[7] <= sfr_wdata[7];
        en[7]  <= sfr_wdata[6];
        typ[3] <= sfr_wdata[4];
        pri[6] <= sfr_wdata[3];
        en[6]  <= sfr_wdata[2];
        typ[2] <= sfr_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '1;
      s2  <= '1;
      s3  <= '1;
      flg <= '0;
    end else begin
      s1 <= ext_n;
      s2 <= s1;
      s3 <= s2;
      for (int i = 0; i < 4; i++) begin
        if (!typ[i])       flg[i] <= ~s2[i];
        else if (fall[i])  flg[i] <= 1'b1;
        else if (svc[i])   flg[i] <= 1'b0;
        else if (sw_we[i]) flg[i] <= sw_val[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_hi    <= 1'b0;
      ins_lo    <= 1'b0;
      vec_valid <= 1'b0;
      vec       <= '0;
      idx       <= '0;
    end else begin
      if (reti) begin
        if (ins_hi) ins_hi <= 1'b0;
        else        ins_lo <= 1'b0;
      end
      if (fire) begin
        if (take_hi) ins_hi <= 1'b1;
        else         ins_lo <= 1'b1;
        idx <= gidx;
        vec <= {2'b00, gidx, 3'b011};
      end
      vec_valid <= fire;
    end
  end

  always_comb begin
    case (sfr_addr)
      A_EN:    sfr_rdata = {ea, 1'b0, en[5:0]};
      A_PRI:   sfr_rdata = {2'b00, pri[5:0]};
      A_EXL:   sfr_rdata = {4'h0, flg[1], typ[1], flg[0], typ[0]};
      A_EXH:   sfr_rdata = {pri[7], en[7], flg[3], typ[3], pri[6], en[6], flg[2], typ[2]};
      default: sfr_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vec_valid,
  input logic [7:0] vec,
  input logic [2:0] idx,
  input logic       ea,
  input logic [7:0] pri,
  input logic       ins_hi,
  input logic       ins_lo
);
  logic [7:0] pri_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pri_d <= '0;
    else        pri_d <= pri;

  p_vec_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec[2:0] == 3'b011 && vec[7:6] == 2'b00);

  p_gate_ea_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ea));

  p_hi_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ins_hi) |-> !vec_valid);

  p_lo_only_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && $past(ins_lo) |-> pri_d[idx]);

  p_stack_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ins_hi || ins_lo);
endmodule

bind irq_ctrl8 irq_ctrl8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec(vec), .idx(idx),
  .ea(ea), .pri(pri), .ins_hi(ins_hi), .ins_lo(ins_lo)
);

// File: tb/tb_irq_ctrl8.sv
module tb_irq_ctrl8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_n = 4'hF;
  logic [2:0] tmr_req = 3'b000;
  logic       ser_req = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       reti = 1'b0;
  logic       vec_valid;
  logic [7:0] vec;
  logic [2:0] idx;

  int checks = 0;
  int fails = 0;
  int unexp = 0;
  logic [2:0] q[$];

  irq_ctrl8 dut (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (q.size() == 0) begin
        unexp++;
        check(0, "R5/R4 unexpected vector idx", idx, 8);
      end else begin
        logic [2:0] e;
        e = q.pop_front();
        check(idx == e, "R2/R3 source index", idx, e);
        check(vec == {2'b00, e, 3'b011}, "R2 vector", vec, {2'b00, e, 3'b011});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sfr_addr = a;
    #1;
    check(sfr_rdata == exp, tag, sfr_rdata, exp);
  endtask

  task automatic push(input logic [2:0] e);
    q.push_back(e);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 40 && q.size() != 0; i++) @(negedge clk);
    check(q.size() == 0, tag, q.size(), 0);
    q.delete();
  endtask

  task automatic ret();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pin(input int p);
    @(negedge clk); ext_n[p] = 1'b0;
    settle(3);
    ext_n[p] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int u;
    settle(2);
    #1 check(vec_valid == 1'b0, "R1 vec_valid after reset", vec_valid, 0);
    rst_n = 1'b1;
    rd_chk(8'hA8, 8'h00, "R1 A8H reset");
    rd_chk(8'hB8, 8'h00, "R1 B8H reset");
    rd_chk(8'h88, 8'h00, "R1 88H reset");
    rd_chk(8'hC0, 8'h00, "R1 C0H reset");

    // R4: global enable off blocks a held request
    wr(8'hA8, 8'h02);
    u = unexp;
    tmr_req[0] = 1'b1;
    settle(8);
    check(unexp == u && q.size() == 0, "R4 global disable", unexp - u, 0);
    push(1);
    wr(8'hA8, 8'h82);
    drain("R4 timer0 after enable");
    tmr_req[0] = 1'b0;
    ret();

    // R3: fixed order within low level
    wr(8'hA8, 8'hBF);
    push(1);
    @(negedge clk); tmr_req = 3'b101; ser_req = 1'b1;
    drain("R3 first timer0");
    tmr_req[0] = 1'b0; push(4); ret();
    drain("R3 then serial");
    ser_req = 1'b0; push(5); ret();
    drain("R3 then timer2");
    tmr_req[2] = 1'b0; ret();

    // R5: nesting rules
    wr(8'hB8, 8'h08);
    wr(8'hA8, 8'hAA);
    push(5); tmr_req[2] = 1'b1;
    drain("R5 low timer2");
    push(3); tmr_req[1] = 1'b1;
    drain("R5 high timer1 preempts");
    u = unexp;
    tmr_req[0] = 1'b1;
    settle(6);
    check(unexp == u, "R5 nothing preempts high", unexp - u, 0);
    tmr_req[1] = 1'b0; ret();
    settle(6);
    check(unexp == u, "R5 low waits for low", unexp - u, 0);
    tmr_req[2] = 1'b0; push(1); ret();
    drain("R5 timer0 after release");
    tmr_req[0] = 1'b0; ret();
    wr(8'hB8, 8'h00);

    // R6/R9: layout and software flag access
    wr(8'hA8, 8'h00);
    wr(8'hC0, 8'hDD);
    rd_chk(8'hC0, 8'hDD, "R6 C0H layout readback");
    wr(8'hC0, 8'hFF);
    rd_chk(8'hC0, 8'hFF, "R9 software flag set");
    wr(8'hC0, 8'hDD);
    rd_chk(8'hC0, 8'hDD, "R9 software flag clear");

    // R9: hardware set wins over software clear
    wr(8'hC0, 8'h03);
    @(negedge clk); ext_n[2] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = 8'hC0; sfr_wdata = 8'h01;
    @(negedge clk);
    sfr_we = 1'b0;
    ext_n[2] = 1'b1;
    rd_chk(8'hC0, 8'h03, "R9 edge beats software clear");
    wr(8'hC0, 8'h01);
    settle(4);
    rd_chk(8'hC0, 8'h01, "R9 clear after rising pin");

    // R7: edge mode on external 2
    wr(8'hC0, 8'h05);
    pulse_pin(2);
    settle(4);
    rd_chk(8'hC0, 8'h07, "R7 edge sets flag");
    push(6);
    wr(8'hA8, 8'h80);
    drain("R7 external2 serviced");
    rd_chk(8'hC0, 8'h05, "R7 flag cleared on service");
    ret();

    // R8: level mode on external 3
    wr(8'hC0, 8'h40);
    push(7);
    @(negedge clk); ext_n[3] = 1'b0;
    drain("R8 external3 level");
    rd_chk(8'hC0, 8'h60, "R8 flag kept after service");
    ext_n[3] = 1'b1;
    settle(5);
    rd_chk(8'hC0, 8'h40, "R8 flag follows pin");
    ret();

    // R3: external 2 before external 3
    wr(8'hC0, 8'h44);
    push(6);
    @(negedge clk); ext_n[3:2] = 2'b00;
    drain("R3 external2 first");
    ext_n[2] = 1'b1;
    settle(5);
    push(7); ret();
    drain("R3 external3 second");
    ext_n[3] = 1'b1;
    settle(5);
    ret();
    wr(8'hC0, 8'h00);

    // R10: external 0 edge mode through 88H
    wr(8'hA8, 8'h81);
    wr(8'h88, 8'h01);
    rd_chk(8'h88, 8'h01, "R10 88H type bit");
    push(0);
    pulse_pin(0);
    drain("R10 external0 vector");
    rd_chk(8'h88, 8'h01, "R10 flag0 cleared on service");
    ret();
    wr(8'hA8, 8'h00);
    wr(8'h88, 8'h04);
    pulse_pin(1);
    settle(4);
    rd_chk(8'h88, 8'h0C, "R10 flag1 set by edge");

    settle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule